// File: doc/BRIEF.md
# Shared Prescaler / Watchdog Postscaler

One binary divider, eight bits deep, serves one of two clients at a time. The first client is a general-purpose timer, which uses it to slow down its increment tick. The second is a watchdog, which uses it to stretch the interval between its raw timeout ticks and the reset pulse it finally issues. A single ownership input selects the client that gets the divider. A three-bit select input picks the division ratio. The client that does not own the divider gets its own tick through a plain path with no division.

The ratio codes are one octave apart for the two clients. For the timer, select value `s` divides by 2^(s+1), so the range is 1:2 to 1:256. For the watchdog, the same code divides by 2^s, so the range is 1:1 to 1:128, and code 0 is a straight pass-through. Three events restart the count from zero: a timer-register write while the timer owns the divider, a watchdog-clear command while the watchdog owns it, and any change of ownership. Every output pulse is registered. It appears exactly one clock after the input tick that caused it.

Top module: `shared_prescaler`

## Requirements
- R1: During reset and in the first cycle after it, both outputs are low. After reset the divider holds zero and the timer owns it.
- R2: With `own_wdt_i`=0, `tmr_inc_o` pulses for one cycle, one clock after every 2^(s+1)-th counted `tmr_tick_i` since the last clear, where s=`ratio_i`. It stays low in every other cycle.
- R3: With `own_wdt_i`=1, `wdt_rst_o` pulses one clock after every 2^s-th counted `wdt_tick_i` since the last clear. With s=0, every counted tick produces a pulse.
- R4: The client that does not own the divider gets an undivided, one-cycle-delayed copy of its tick. This is `tmr_inc_o` when `own_wdt_i`=1, and `wdt_rst_o` when `own_wdt_i`=0.
- R5: While the timer owns the divider, `tmr_wr_i` resets the count to zero, and `wdt_clr_i` has no effect on the count.
- R6: While the watchdog owns the divider, `wdt_clr_i` resets the count to zero, and `tmr_wr_i` has no effect on the count.
- R7: In any cycle where `own_wdt_i` differs from its value in the previous cycle, the count is reset to zero. This also applies to the first cycle after reset, compared against timer ownership.
- R8: If a clear and an owner tick arrive in the same cycle, the clear wins. That tick is not counted and produces no pulse, even at watchdog ratio 1:1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_wdt_i | input | 1 | Divider owner: 0 = timer, 1 = watchdog |
| ratio_i | input | 3 | Ratio select code |
| tmr_tick_i | input | 1 | Timer source tick, one cycle per event |
| wdt_tick_i | input | 1 | Watchdog timeout tick, one cycle per event |
| tmr_wr_i | input | 1 | Timer register write strobe |
| wdt_clr_i | input | 1 | Watchdog clear command strobe |
| tmr_inc_o | output | 1 | Timer increment pulse |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The bench sweeps all eight ratio codes for both owners, using an irregular tick pattern. It checks the first pulse after a clear, which catches a design that taps the rising edge of a counter bit and so fires half a period early. It also catches a design that applies the timer's octave to the watchdog, because that design would divide by twice the intended ratio, or would never pass ticks straight through at code 0. The bench drives the non-owner's clear strobe in the middle of a count and switches ownership in the middle of a count. A design that listens to the wrong clear, or that carries a stale count across a handover, shifts its next pulse. Finally, the bench drives a clear together with a tick, which exposes a design that lets the tick through.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic {
    OWN_TMR = 1'b0,
    OWN_WDT = 1'b1
  } owner_e;

  // Division period for a select code and owner: the watchdog is one octave below.
  function automatic int unsigned div_period(input int unsigned sel, input owner_e own);
    return (own == OWN_TMR) ? (32'd1 << (sel + 1)) : (32'd1 << sel);
  endfunction

  // Index of the highest counter bit whose low run must be all ones for a wrap.
  // A value of -1 means the period is one tick, so every counted tick wraps.
  function automatic int tap_index(input int unsigned sel, input owner_e own);
    return (own == OWN_TMR) ? int'(sel) : int'(sel) - 1;
  endfunction

endpackage

// File: rtl/psc_owner_mux.sv
module psc_owner_mux
  import psc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  owner_e owner_i,
  input  logic   tmr_tick_i,
  input  logic   wdt_tick_i,
  input  logic   tmr_wr_i,
  input  logic   wdt_clr_i,
  output logic   own_tick_o,
  output logic   div_clr_o,
  output logic   swap_o
);

  owner_e owner_q;

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_TMR;
    else        owner_q <= owner_i;
  end

  assign swap_o = (owner_i != owner_q);

  always_comb begin
    if (owner_i == OWN_WDT) begin
      own_tick_o = wdt_tick_i;
      div_clr_o  = swap_o | wdt_clr_i;
    end else begin
      own_tick_o = tmr_tick_i;
      div_clr_o  = swap_o | tmr_wr_i;
    end
  end

endmodule

// File: rtl/psc_divider.sv
module psc_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/psc_tap_select.sv
module psc_tap_select
  import psc_pkg::*;
#(
  parameter int W     = 8,
  parameter int SEL_W = 3
) (
  input  logic [W-1:0]     cnt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  owner_e           owner_i,
  output logic             wrap_o
);

  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

  // ones_run[k] is set when bits k..0 are all ones, so the next increment
  // carries out of bit k and closes one period of length 2^(k+1).
  logic [W-1:0] ones_run;

  genvar k;
  generate
    for (k = 0; k < W; k++) begin : g_run
      assign ones_run[k] = &cnt_i[k:0];
    end
  endgenerate

  int             idx;
  logic [IDX_W-1:0] idx_sel;

  always_comb begin
    idx     = tap_index(int'(sel_i), owner_i);
    idx_sel = IDX_W'(idx < 0 ? 0 : idx);
    wrap_o  = (idx < 0) ? 1'b1 : ones_run[idx_sel];
  end

endmodule

// File: rtl/psc_out_stage.sv
module psc_out_stage
  import psc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  owner_e owner_i,
  input  logic   div_pulse_i,
  input  logic   tmr_tick_i,
  input  logic   wdt_tick_i,
  output logic   tmr_inc_o,
  output logic   wdt_rst_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_inc_o <= 1'b0;
      wdt_rst_o <= 1'b0;
    end else if (owner_i == OWN_WDT) begin
      tmr_inc_o <= tmr_tick_i;
      wdt_rst_o <= div_pulse_i;
    end else begin
      tmr_inc_o <= div_pulse_i;
      wdt_rst_o <= wdt_tick_i;
    end
  end

endmodule

// File: rtl/shared_prescaler.sv
module shared_prescaler
  import psc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             own_wdt_i,
  input  logic [SEL_W-1:0] ratio_i,
  input  logic             tmr_tick_i,
  input  logic             wdt_tick_i,
  input  logic             tmr_wr_i,
  input  logic             wdt_clr_i,
  output logic             tmr_inc_o,
  output logic             wdt_rst_o
);

  owner_e           owner;
  logic             own_tick;
  logic             div_clr;
  logic             swap;
  logic [CNT_W-1:0] div_cnt;
  logic             wrap;
  logic             div_pulse;

  assign owner = own_wdt_i ? OWN_WDT : OWN_TMR;

  psc_owner_mux u_owner (
    .clk        (clk),
    .rst_n      (rst_n),
    .owner_i    (owner),
    .tmr_tick_i (tmr_tick_i),
    .wdt_tick_i (wdt_tick_i),
    .tmr_wr_i   (tmr_wr_i),
    .wdt_clr_i  (wdt_clr_i),
    .own_tick_o (own_tick),
    .div_clr_o  (div_clr),
    .swap_o     (swap)
  );

  psc_divider #(.W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (div_clr),
    .inc_i (own_tick),
    .cnt_o (div_cnt)
  );

  psc_tap_select #(.W(CNT_W), .SEL_W(SEL_W)) u_tap (
    .cnt_i   (div_cnt),
    .sel_i   (ratio_i),
    .owner_i (owner),
    .wrap_o  (wrap)
  );

  // A period closes on the counted tick that carries out of the tap bit.
  assign div_pulse = own_tick & ~div_clr & wrap;

  psc_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .owner_i     (owner),
    .div_pulse_i (div_pulse),
    .tmr_tick_i  (tmr_tick_i),
    .wdt_tick_i  (wdt_tick_i),
    .tmr_inc_o   (tmr_inc_o),
    .wdt_rst_o   (wdt_rst_o)
  );

endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         own_wdt_i,
  input logic         tmr_tick_i,
  input logic         wdt_tick_i,
  input logic         tmr_wr_i,
  input logic         wdt_clr_i,
  input logic         tmr_inc_o,
  input logic         wdt_rst_o,
  input logic         div_clr,
  input logic         swap,
  input logic [W-1:0] div_cnt
);

  p_undiv_tmr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    own_wdt_i |=> (tmr_inc_o == $past(tmr_tick_i)));

  p_undiv_wdt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !own_wdt_i |=> (wdt_rst_o == $past(wdt_tick_i)));

  p_no_tick_no_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_wdt_i && !tmr_tick_i) |=> !tmr_inc_o);

  p_no_tick_no_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (own_wdt_i && !wdt_tick_i) |=> !wdt_rst_o);

  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_wdt_i && tmr_wr_i) |=> (div_cnt == '0));

  p_wdtclr_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_wdt_i && wdt_clr_i) |=> (div_cnt == '0));

  p_swap_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swap |-> div_clr);

  p_clear_beats_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_wdt_i && tmr_wr_i) |=> !tmr_inc_o);

  p_wdt_clear_beats_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (own_wdt_i && wdt_clr_i) |=> !wdt_rst_o);

  p_count_moves_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !div_clr |=> (div_cnt == $past(div_cnt)) || (div_cnt == $past(div_cnt) + 1'b1));

endmodule

bind shared_prescaler psc_checker #(.W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .own_wdt_i  (own_wdt_i),
  .tmr_tick_i (tmr_tick_i),
  .wdt_tick_i (wdt_tick_i),
  .tmr_wr_i   (tmr_wr_i),
  .wdt_clr_i  (wdt_clr_i),
  .tmr_inc_o  (tmr_inc_o),
  .wdt_rst_o  (wdt_rst_o),
  .div_clr    (div_clr),
  .swap       (swap),
  .div_cnt    (div_cnt)
);

// File: tb/shared_prescaler_tb.sv
module shared_prescaler_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       own_wdt_i;
  logic [2:0] ratio_i;
  logic       tmr_tick_i, wdt_tick_i, tmr_wr_i, wdt_clr_i;
  logic       tmr_inc_o, wdt_rst_o;

  int total = 0;
  int bad   = 0;
  int m     = 0;
  logic asg_prev = 1'b0;

  always #2 clk = ~clk;

  shared_prescaler u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .own_wdt_i  (own_wdt_i),
    .ratio_i    (ratio_i),
    .tmr_tick_i (tmr_tick_i),
    .wdt_tick_i (wdt_tick_i),
    .tmr_wr_i   (tmr_wr_i),
    .wdt_clr_i  (wdt_clr_i),
    .tmr_inc_o  (tmr_inc_o),
    .wdt_rst_o  (wdt_rst_o)
  );

  task automatic check(input logic got, input logic exp, input string tag, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got %0b exp %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, predict, sample at the next falling edge.
  task automatic step(input logic tt, input logic wt, input logic tw, input logic wc,
                      input logic asg, input logic [2:0] r,
                      input string tag_t, input string tag_w);
    logic clr, own, dp, et, ew;
    int   n;
    tmr_tick_i = tt; wdt_tick_i = wt; tmr_wr_i = tw; wdt_clr_i = wc;
    own_wdt_i = asg; ratio_i = r;
    clr = (asg != asg_prev) || (asg ? wc : tw);
    own = asg ? wt : tt;
    n   = asg ? (1 << r) : (2 << r);
    dp  = 1'b0;
    if (clr) m = 0;
    else if (own) begin
      m  = m + 1;
      dp = ((m % n) == 0);
    end
    asg_prev = asg;
    et = asg ? tt : dp;
    ew = asg ? dp : wt;
    @(posedge clk);
    @(negedge clk);
    check(tmr_inc_o, et, tag_t, "tmr_inc_o");
    check(wdt_rst_o, ew, tag_w, "wdt_rst_o");
  endtask

  task automatic idle_ticks(input int cnt, input logic asg, input logic [2:0] r,
                            input string tag_t, input string tag_w);
    for (int i = 0; i < cnt; i++) step(!asg, asg, 1'b0, 1'b0, asg, r, tag_t, tag_w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; own_wdt_i = 1'b0; ratio_i = 3'd0;
    tmr_tick_i = 1'b0; wdt_tick_i = 1'b0; tmr_wr_i = 1'b0; wdt_clr_i = 1'b0;
    repeat (3) @(posedge clk);
    tmr_tick_i = 1'b1;
    @(negedge clk);
    check(tmr_inc_o, 1'b0, "R1", "tmr_inc_o in reset");
    check(wdt_rst_o, 1'b0, "R1", "wdt_rst_o in reset");
    rst_n = 1'b1;
    m = 0; asg_prev = 1'b0;
    // R1: the first tick after reset must not complete a 1:2 period
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R1", "R1");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R1", "R1");

    // R2 sweep with timer owning; R4 on the watchdog path meanwhile
    for (int r = 0; r < 8; r++) begin
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'(r), "R5", "R4");
      for (int i = 0; i < 3 * (2 << r) + 4; i++)
        step((i % 5) != 3, (i % 3) == 1, 1'b0, 1'b0, 1'b0, 3'(r), "R2", "R4");
    end

    // R3 sweep with watchdog owning; R4 on the timer path meanwhile
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, "R7", "R7");
    for (int r = 0; r < 8; r++) begin
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'(r), "R4", "R6");
      for (int i = 0; i < 3 * (1 << r) + 4; i++)
        step((i % 2) == 0, (i % 7) != 5, 1'b0, 1'b0, 1'b1, 3'(r), "R4", "R3");
    end

    // R5: timer write mid-count restarts; watchdog clear is ignored
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, "R7", "R7");
    idle_ticks(5, 1'b0, 3'd2, "R5", "R5");
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, "R5", "R5");
    idle_ticks(3, 1'b0, 3'd2, "R5", "R5");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, "R5", "R5");
    idle_ticks(9, 1'b0, 3'd2, "R5", "R5");

    // R6: watchdog clear mid-count restarts; timer write is ignored
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, "R7", "R7");
    idle_ticks(5, 1'b1, 3'd3, "R6", "R6");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, "R6", "R6");
    idle_ticks(2, 1'b1, 3'd3, "R6", "R6");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, "R6", "R6");
    idle_ticks(9, 1'b1, 3'd3, "R6", "R6");

    // R7: ownership handover mid-count drops the stale count both ways
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, "R7", "R7");
    idle_ticks(3, 1'b0, 3'd1, "R7", "R7");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2, "R7", "R7");
    idle_ticks(3, 1'b1, 3'd2, "R7", "R7");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, "R7", "R7");
    idle_ticks(5, 1'b0, 3'd1, "R7", "R7");

    // R8: clear and tick in one cycle, for the timer and for watchdog 1:1
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R8", "R8");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R8", "R8");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R8", "R8");
    idle_ticks(3, 1'b0, 3'd0, "R8", "R8");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, "R8", "R8");
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, "R8", "R8");
    idle_ticks(2, 1'b1, 3'd0, "R8", "R8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule